// File: doc/BRIEF.md
# Supply Window Monitor with Latched Alert

This block watches five supply measurements (channel 0 to channel 4: 2.5 V, core, own supply, 5 V, 12 V). Each channel has its own programmable 8-bit lower and upper bound. When the measurement path presents a new 10-bit result, it pulses that channel's valid strobe. The block then compares the result's top eight bits against the channel's window. A result outside the window latches a status bit and pulls the active-low alert line down.

The host reaches the bounds, the status bits and a per-channel alert mask through a plain register port. Read data is combinational from the address. A read or write takes effect on the clock edge where the strobe is high. The host first acknowledges the alert through a one-cycle pulse, which stands in for the bus alert-response cycle. It then reads status. The alert goes away only if, after that read, no unmasked channel is still flagged.

Top module: `volt_window_alert`

## Requirements
- R1: After reset, every lower bound reads 0x00, every upper bound reads 0xFF, status (0x41) and mask (0x42) read 0x00, and alertN is high.
- R2: Channel i's lower bound is at address 0x44+2i and its upper bound at 0x45+2i. Both are written with regWr and read back unchanged. A write to one bound leaves every other bound unchanged.
- R3: On a valid strobe, a channel is out of window when bits [9:2] of its result are greater than the upper bound or less than the lower bound. A value equal to either bound is inside. An out-of-window result sets status bit i (bit i of address 0x41) at the next clock edge.
- R4: Comparison happens only on a valid strobe. Changing the result data without a strobe, or changing a bound, leaves status unchanged.
- R5: A status bit stays set after later in-window results until a status read.
- R6: A status read returns the status before clearing. It clears a bit only if that channel's most recent result was inside its window. Bits whose latest result is still outside stay set.
- R7: alertN goes low at the clock edge after a strobe that gives an out-of-window result on an unmasked channel.
- R8: Mask bit i (bit i of address 0x42) stops channel i from pulling alertN low, while its status bit is still set.
- R9: alertN returns high only on a status read that follows an alertAck pulse given while the alert was low, and only when no unmasked status bit remains after that read. A status read without a prior acknowledge keeps alertN low.
- R10: When an out-of-window strobe and a clearing status read fall in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| measValid | input | 5 | Per-channel new-result strobe |
| measData | input | 50 | Five 10-bit results, channel i at bits [10i+9:10i] |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (status read clears) |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr; 0 for unmapped addresses |
| alertAck | input | 1 | Alert acknowledge pulse |
| alertN | output | 1 | Active-low alert |

## Verification
The hardest case to reach is a clearing status read that lands in the same cycle as a new out-of-window strobe on the same channel, after that channel's previous result was back inside. The bench reaches it by first leaving an in-window result behind a sticky bit, then driving the read strobe and the failing strobe on one falling edge. A second hard case is a partial clear: two channels are flagged, one recovers, and the alert must survive an acknowledged read until the other recovers too. The bench builds it from a fixed order of strobes, acknowledge and reads.

// File: rtl/vwa_pkg.sv
package vwa_pkg;
  localparam int CH_IDX_W = 3;

  typedef struct packed {
    logic                wr;
    logic                statusRd;
    logic                hitLim;
    logic                hitStat;
    logic                hitMask;
    logic                limHigh;
    logic [CH_IDX_W-1:0] limCh;
  } vwaStrobe_t;
endpackage

// File: rtl/vwa_ctrl.sv
module vwa_ctrl
  import vwa_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int ADDR_W    = 8,
  parameter int LIM_BASE  = 'h44,
  parameter int STAT_ADDR = 'h41,
  parameter int MASK_ADDR = 'h42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              alertAck,
  input  logic              setUnmasked,
  input  logic              leftUnmasked,
  output vwaStrobe_t        strb,
  output logic              alertActive
);
  localparam int LIM_SPAN = 2 * NUM_CH;
  localparam logic [ADDR_W-1:0] LIM_LO_A = ADDR_W'(LIM_BASE);
  localparam logic [ADDR_W-1:0] LIM_HI_A = ADDR_W'(LIM_BASE + LIM_SPAN);

  logic [ADDR_W-1:0] offset;
  logic              armed;

  always_comb begin
    offset        = regAddr - LIM_LO_A;
    strb.wr       = regWr;
    strb.hitLim   = (regAddr >= LIM_LO_A) && (regAddr < LIM_HI_A);
    strb.hitStat  = (regAddr == ADDR_W'(STAT_ADDR));
    strb.hitMask  = (regAddr == ADDR_W'(MASK_ADDR));
    strb.statusRd = regRd && strb.hitStat;
    strb.limHigh  = offset[0];
    strb.limCh    = CH_IDX_W'(offset >> 1);
  end

  // Alert latch: a new unmasked fault always wins; release needs ack, then read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      alertActive <= 1'b0;
      armed       <= 1'b0;
    end else if (setUnmasked) begin
      alertActive <= 1'b1;
    end else if (alertActive && armed && strb.statusRd && !leftUnmasked) begin
      alertActive <= 1'b0;
      armed       <= 1'b0;
    end else if (alertActive && alertAck) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/vwa_datapath.sv
module vwa_datapath
  import vwa_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int MEAS_W = 10,
  parameter int LIM_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  vwaStrobe_t               strb,
  input  logic [LIM_W-1:0]         regWdata,
  input  logic [NUM_CH-1:0]        measValid,
  input  logic [NUM_CH*MEAS_W-1:0] measData,
  output logic [NUM_CH-1:0]        statusQ,
  output logic [NUM_CH-1:0]        statusNext,
  output logic [NUM_CH-1:0]        maskQ,
  output logic [NUM_CH-1:0]        setVec,
  output logic [LIM_W-1:0]         rdData
);
  localparam int EXTRA = MEAS_W - LIM_W;

  logic [LIM_W-1:0]  limLo [NUM_CH];
  logic [LIM_W-1:0]  limHi [NUM_CH];
  logic [NUM_CH-1:0] outNow;
  logic [NUM_CH-1:0] lastOut;
  logic [NUM_CH-1:0] clrVec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    logic [MEAS_W-1:0] sample;
    logic              selThis;

    assign sample  = measData[ch*MEAS_W +: MEAS_W];
    assign selThis = strb.wr && strb.hitLim && (strb.limCh == CH_IDX_W'(ch));
    // Widened bounds make the compare act on the top LIM_W bits of the result.
    assign outNow[ch] = (sample > {limHi[ch], {EXTRA{1'b1}}})
                     || (sample < {limLo[ch], {EXTRA{1'b0}}});

    always_ff @(posedge clk) begin
      if (!rstN) begin
        limLo[ch]   <= '0;
        limHi[ch]   <= '1;
        lastOut[ch] <= 1'b0;
      end else begin
        if (selThis && !strb.limHigh) limLo[ch] <= regWdata;
        if (selThis &&  strb.limHigh) limHi[ch] <= regWdata;
        if (measValid[ch])            lastOut[ch] <= outNow[ch];
      end
    end
  end

  assign setVec     = measValid & outNow;
  assign clrVec     = strb.statusRd ? ~lastOut : '0;
  assign statusNext = (statusQ & ~clrVec) | setVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusNext;
      if (strb.wr && strb.hitMask) maskQ <= regWdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.hitStat)      rdData = {{(LIM_W-NUM_CH){1'b0}}, statusQ};
    else if (strb.hitMask) rdData = {{(LIM_W-NUM_CH){1'b0}}, maskQ};
    else if (strb.hitLim)  rdData = strb.limHigh ? limHi[strb.limCh] : limLo[strb.limCh];
  end
endmodule

// File: rtl/volt_window_alert.sv
module volt_window_alert
  import vwa_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int MEAS_W    = 10,
  parameter int LIM_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int LIM_BASE  = 'h44,
  parameter int STAT_ADDR = 'h41,
  parameter int MASK_ADDR = 'h42
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        measValid,
  input  logic [NUM_CH*MEAS_W-1:0] measData,
  input  logic                     regWr,
  input  logic                     regRd,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [LIM_W-1:0]         regWdata,
  output logic [LIM_W-1:0]         regRdata,
  input  logic                     alertAck,
  output logic                     alertN
);
  vwaStrobe_t        strb;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] statusNext;
  logic [NUM_CH-1:0] maskQ;
  logic [NUM_CH-1:0] setVec;
  logic              alertActive;
  logic              setUnmasked;
  logic              leftUnmasked;

  assign setUnmasked  = |(setVec & ~maskQ);
  assign leftUnmasked = |(statusNext & ~maskQ);
  assign alertN       = ~alertActive;

  vwa_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .LIM_BASE(LIM_BASE),
    .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .alertAck(alertAck), .setUnmasked(setUnmasked), .leftUnmasked(leftUnmasked),
    .strb(strb), .alertActive(alertActive)
  );

  vwa_datapath #(
    .NUM_CH(NUM_CH), .MEAS_W(MEAS_W), .LIM_W(LIM_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .measValid(measValid), .measData(measData),
    .statusQ(statusQ), .statusNext(statusNext), .maskQ(maskQ),
    .setVec(setVec), .rdData(regRdata)
  );
endmodule

// File: rtl/vwa_checker.sv
module vwa_checker #(
  parameter int NUM_CH    = 5,
  parameter int ADDR_W    = 8,
  parameter int STAT_ADDR = 'h41
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] measValid,
  input logic [NUM_CH-1:0] maskQ,
  input logic [NUM_CH-1:0] statusQ,
  input logic              regRd,
  input logic [ADDR_W-1:0] regAddr,
  input logic              alertN
);
  logic statRead;
  assign statRead = regRd && (regAddr == ADDR_W'(STAT_ADDR));

  AST_STATUS_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) != '0) |-> $past(|measValid)); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusQ) & ~statusQ) != '0) |-> $past(statRead)); // R5

  AST_ALERT_FROM_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alertN) |-> $past(|(measValid & ~maskQ))); // R8

  AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alertN) |-> $past(statRead)); // R9

  AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alertN) |-> ((statusQ & ~$past(maskQ)) == '0)); // R9
endmodule

bind volt_window_alert vwa_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) chk (
  .clk(clk), .rstN(rstN), .measValid(measValid), .maskQ(maskQ),
  .statusQ(statusQ), .regRd(regRd), .regAddr(regAddr), .alertN(alertN)
);

// File: tb/volt_window_alert_test.sv
`timescale 1ns/1ps
module volt_window_alert_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  measValid;
  logic [49:0] measData;
  logic        regWr, regRd;
  logic [7:0]  regAddr, regWdata;
  logic [7:0]  regRdata;
  logic        alertAck;
  logic        alertN;
  int checks = 0;
  int failures = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  volt_window_alert uut (
    .clk(clk), .rstN(rstN), .measValid(measValid), .measData(measData),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .alertAck(alertAck), .alertN(alertN)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; measValid = '0; measData = '0; regWr = 1'b0; regRd = 1'b0;
    regAddr = '0; regWdata = '0; alertAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic strobe(input int ch, input logic [9:0] val);
    measData[ch*10 +: 10] = val; measValid[ch] = 1'b1;
    @(negedge clk);
    measValid = '0;
  endtask

  task automatic ack();
    alertAck = 1'b1;
    @(negedge clk);
    alertAck = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    for (int ch = 0; ch < 5; ch++) begin
      rdReg(8'h44 + 8'(2*ch), v); check("R1 low bound default", v, 8'h00);
      rdReg(8'h45 + 8'(2*ch), v); check("R1 high bound default", v, 8'hFF);
    end
    rdReg(8'h41, v); check("R1 status default", v, 0);
    rdReg(8'h42, v); check("R1 mask default", v, 0);
    check("R1 alertN idle", alertN, 1);
  endtask

  task automatic testLimits();
    doReset();
    wrReg(8'h48, 8'h40); wrReg(8'h49, 8'hC0); wrReg(8'h4D, 8'h33);
    rdReg(8'h48, v); check("R2 ch2 low", v, 8'h40);
    rdReg(8'h49, v); check("R2 ch2 high", v, 8'hC0);
    rdReg(8'h4D, v); check("R2 ch4 high", v, 8'h33);
    rdReg(8'h4A, v); check("R2 ch3 low untouched", v, 8'h00);
    rdReg(8'h4B, v); check("R2 ch3 high untouched", v, 8'hFF);
  endtask

  task automatic testCompare();
    doReset();
    wrReg(8'h48, 8'h40); wrReg(8'h49, 8'hC0);
    strobe(2, 10'h303);  // top bits 0xC0, equal to high
    rdReg(8'h41, v); check("R3 equal high inside", v, 0);
    check("R3 alert idle inside", alertN, 1);
    strobe(2, 10'h0FF);  // top bits 0x3F < 0x40
    check("R7 alert low after fault", alertN, 0);
    rdReg(8'h41, v); check("R3 below low sets bit2", v, 8'h04);
    strobe(2, 10'h100);  // 0x40, equal to low, inside
    rdReg(8'h41, v); check("R5 sticky after recovery", v, 8'h04);
    rdReg(8'h41, v); check("R6 cleared after read", v, 0);
    check("R9 no ack keeps alert", alertN, 0);
    ack();
    rdReg(8'h41, v);
    check("R9 ack plus read releases", alertN, 1);
    strobe(2, 10'h304);  // 0xC1 above high
    rdReg(8'h41, v); check("R3 above high sets bit2", v, 8'h04);
  endtask

  task automatic testNoStrobe();
    doReset();
    wrReg(8'h45, 8'h80);
    measData[9:0] = 10'h3FC;
    repeat (3) @(negedge clk);
    rdReg(8'h41, v); check("R4 data without strobe", v, 0);
    check("R4 alert without strobe", alertN, 1);
    strobe(0, 10'h200);
    wrReg(8'h45, 8'h10);
    repeat (2) @(negedge clk);
    rdReg(8'h41, v); check("R4 bound change no effect", v, 0);
  endtask

  task automatic testPartial();
    doReset();
    wrReg(8'h47, 8'h80); wrReg(8'h4A, 8'h50);
    strobe(1, 10'h3FC); strobe(3, 10'h000);
    strobe(1, 10'h100);
    ack();
    rdReg(8'h41, v); check("R6 both flagged", v, 8'h0A);
    rdReg(8'h41, v); check("R6 only ch3 left", v, 8'h08);
    check("R9 alert held by ch3", alertN, 0);
    strobe(3, 10'h200);
    rdReg(8'h41, v); check("R6 ch3 still read", v, 8'h08);
    check("R9 release when clean", alertN, 1);
    rdReg(8'h41, v); check("R6 all clear", v, 0);
  endtask

  task automatic testMask();
    doReset();
    wrReg(8'h42, 8'h10); wrReg(8'h4D, 8'h20);
    strobe(4, 10'h3FF);
    check("R8 masked no alert", alertN, 1);
    rdReg(8'h41, v); check("R8 masked sets status", v, 8'h10);
    rdReg(8'h42, v); check("R8 mask readback", v, 8'h10);
    wrReg(8'h44, 8'h10);
    strobe(0, 10'h000);
    check("R7 unmasked fault alerts", alertN, 0);
  endtask

  task automatic testSetWins();
    doReset();
    wrReg(8'h49, 8'h80);
    strobe(2, 10'h3FC);
    strobe(2, 10'h100);
    regRd = 1'b1; regAddr = 8'h41;
    measData[29:20] = 10'h3FC; measValid[2] = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0; measValid = '0;
    check("R10 read returns prior", v, 8'h04);
    rdReg(8'h41, v); check("R10 set wins over clear", v, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testLimits();
    testCompare();
    testNoStrobe();
    testPartial();
    testMask();
    testSetWins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule